// File: doc/BRIEF.md
# Segment Privilege Check Unit

This block holds the processor's current ring (a 2-bit level: 0 is the most trusted, 3 the least) and rules on every protected-mode access request in the same cycle it is presented. A request names its kind, carries a 16-bit segment selector, and comes with the already-decoded fields of the target descriptor: its ring, whether it describes code or data, whether it is conforming, and whether it is present. The block answers with a grant or a fault, a fault code and a sanitised copy of the offending selector.

Control transfers are the only requests that can move the current ring. A call or jump into code at the current ring keeps that ring. A far return to an outer ring loads the selector's requested level as the new ring on the following clock edge. The block also serves I/O-class instructions against the I/O ring field of the flags register, and it hands back a write mask for a flags pop. That mask protects the interrupt-enable bit and the I/O ring field from untrusted code.

Top module: `seg_priv_check`

## Requirements
- R1: After reset the current ring `cpl` is 0. While `req_valid` is low, `grant` and `fault` are 0, `fault_code` is 00, `fault_sel`, `new_cs` and `flags_wmask` are 0, and `cpl` does not change.
- R2: Data segment load (kind 0): a null selector (bits 15:2 all zero) is granted with no further check. Otherwise a general protection fault is raised when max(RPL, cpl) is greater than the descriptor ring. RPL is selector bits 1:0.
- R3: Stack segment load (kind 1) is granted only for a non-null selector whose descriptor is data (`dsc_code`=0) and whose ring equals `cpl`.
- R4: Call/jump (kind 2) into conforming code is granted when the descriptor ring is at most `cpl`. A less trusted target faults. `cpl` keeps its value.
- R5: Call/jump into non-conforming code is granted only when the descriptor ring equals `cpl` and RPL is at most `cpl`. `new_cs` is the selector with bits 1:0 replaced by `cpl`, and `cpl` keeps its value.
- R6: Far return (kind 5) needs RPL ≥ `cpl`. The target ring must be at most RPL for conforming code, or equal to RPL for non-conforming code. When granted, `new_cs` equals the selector and `cpl` becomes RPL on the next clock edge.
- R7: I/O-class instruction (kind 3) is granted only when `cpl` is at most `iopl`; otherwise it faults.
- R8: Flags pop (kind 4) is always granted. `flags_wmask` is 16'hFFFF at ring 0. At any other ring it is 16'hCDFF: bit 9 (interrupt enable) and bits 13:12 (I/O ring) are cleared.
- R9: Fault codes: 00 none, 01 general protection, 10 not present. A null selector on kinds 1, 2 and 5, a wrong code/data type, and a failed ring rule all give 01. These take precedence over 10, which is raised only when every other check passes but `dsc_present` is 0. Kinds 6 and 7 give 01.
- R10: When `fault` is 1, `fault_sel` is the request selector with bits 1:0 cleared; otherwise it is 0.
- R11: `cpl` changes only on the clock edge that follows a granted kind 2 or kind 5 request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 3 | 0 data load, 1 stack load, 2 call/jump, 3 I/O, 4 flags pop, 5 far return |
| sel | input | 16 | Segment selector; bits 1:0 are RPL |
| dsc_dpl | input | 2 | Target descriptor ring |
| dsc_code | input | 1 | Descriptor describes code |
| dsc_conf | input | 1 | Code descriptor is conforming |
| dsc_present | input | 1 | Descriptor present |
| iopl | input | 2 | I/O ring field of the flags register |
| grant | output | 1 | Request allowed |
| fault | output | 1 | Request refused |
| fault_code | output | 2 | 00 none, 01 protection, 10 not present |
| fault_sel | output | 16 | Faulting selector with bits 1:0 cleared |
| new_cs | output | 16 | Code selector to install on a granted transfer |
| flags_wmask | output | 16 | Writable flag bits for a flags pop |
| cpl | output | 2 | Current ring |

## Verification
Every verdict output (`grant`, `fault`, `fault_code`, `fault_sel`, `new_cs`, `flags_wmask`) is combinational in the request and is due in the same cycle. The bench drives each request on the falling edge and samples these outputs shortly after, before the next rising edge. The ring change is due one rising edge later, so `cpl` is sampled just after that edge and compared with the ring the vector expects. Vectors run in sequence so that returns raise the ring, and later vectors are judged at rings 1 and 3.

// File: rtl/seg_priv_check.sv
module seg_priv_check #(
  parameter int SEL_W    = 16,
  parameter int IF_BIT   = 9,
  parameter int IOPL_LSB = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       dsc_dpl,
  input  logic             dsc_code,
  input  logic             dsc_conf,
  input  logic             dsc_present,
  input  logic [1:0]       iopl,
  output logic             grant,
  output logic             fault,
  output logic [1:0]       fault_code,
  output logic [SEL_W-1:0] fault_sel,
  output logic [SEL_W-1:0] new_cs,
  output logic [SEL_W-1:0] flags_wmask,
  output logic [1:0]       cpl
);

  localparam logic [2:0] K_DATA = 3'd0;
  localparam logic [2:0] K_STK  = 3'd1;
  localparam logic [2:0] K_XFER = 3'd2;
  localparam logic [2:0] K_IO   = 3'd3;
  localparam logic [2:0] K_POPF = 3'd4;
  localparam logic [2:0] K_RET  = 3'd5;

  localparam logic [1:0] FC_NONE = 2'b00;
  localparam logic [1:0] FC_GP   = 2'b01;
  localparam logic [1:0] FC_NP   = 2'b10;

  localparam logic [SEL_W-1:0] ALL_ONES  = '1;
  localparam logic [SEL_W-1:0] PROT_BITS =
    (SEL_W'(1) << IF_BIT) | (SEL_W'(3) << IOPL_LSB);

  logic [1:0] rpl, eff;
  logic       is_null, gp, np;
  logic [1:0] verdict;

  assign rpl     = sel[1:0];
  assign eff     = (rpl > cpl) ? rpl : cpl;
  assign is_null = (sel[SEL_W-1:2] == '0);

  always_comb begin
    gp = 1'b0;
    np = 1'b0;
    unique case (req_kind)
      K_DATA: if (!is_null) begin
        gp = eff > dsc_dpl;
        np = !dsc_present;
      end
      K_STK: begin
        gp = is_null || dsc_code || (dsc_dpl != cpl);
        np = !dsc_present;
      end
      K_XFER: begin
        gp = is_null || !dsc_code ||
             (dsc_conf ? (dsc_dpl > cpl) : ((dsc_dpl != cpl) || (rpl > cpl)));
        np = !dsc_present;
      end
      K_RET: begin
        gp = is_null || !dsc_code || (rpl < cpl) ||
             (dsc_conf ? (dsc_dpl > rpl) : (dsc_dpl != rpl));
        np = !dsc_present;
      end
      K_IO:    gp = cpl > iopl;
      K_POPF:  gp = 1'b0;
      default: gp = 1'b1;
    endcase
  end

  assign verdict    = !req_valid ? FC_NONE : gp ? FC_GP : np ? FC_NP : FC_NONE;
  assign fault_code = verdict;
  assign fault      = (verdict != FC_NONE);
  assign grant      = req_valid && !fault;
  assign fault_sel  = fault ? {sel[SEL_W-1:2], 2'b00} : '0;

  assign new_cs = !grant                ? '0 :
                  (req_kind == K_XFER)  ? {sel[SEL_W-1:2], cpl} :
                  (req_kind == K_RET)   ? sel : '0;

  assign flags_wmask = (!req_valid || req_kind != K_POPF) ? '0 :
                       (cpl == 2'd0) ? ALL_ONES : (ALL_ONES & ~PROT_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cpl <= 2'd0;
    else if (grant && (req_kind == K_XFER || req_kind == K_RET))
      cpl <= new_cs[1:0];
  end

  AST_GRANT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && fault)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !fault && flags_wmask == '0)); // R1
  AST_DATA_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_kind == K_DATA && sel[SEL_W-1:2] != '0) |->
      (sel[1:0] <= dsc_dpl && cpl <= dsc_dpl)); // R2
  AST_STACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_kind == K_STK) |-> (dsc_dpl == cpl && !dsc_code)); // R3
  AST_CONF_NO_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_kind == K_XFER && dsc_conf) |-> (dsc_dpl <= cpl)); // R4
  AST_XFER_KEEPS_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_kind == K_XFER) |=> (cpl == $past(cpl))); // R5
  AST_RET_LOADS_RPL: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_kind == K_RET) |=> (cpl == $past(sel[1:0]))); // R6
  AST_IO_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_kind == K_IO) |-> (cpl <= iopl)); // R7
  AST_POPF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_POPF && cpl != 2'd0) |->
      (flags_wmask[IF_BIT] == 1'b0 && flags_wmask[IOPL_LSB+1 -: 2] == 2'b00)); // R8
  AST_FSEL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_sel[1:0] == 2'b00 && fault_sel[SEL_W-1:2] == sel[SEL_W-1:2])); // R10
  AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && (req_kind == K_XFER || req_kind == K_RET)) |=> $stable(cpl)); // R11

endmodule

// File: tb/sim_seg_priv_check.sv
module sim_seg_priv_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [15:0] sel = '0;
  logic [1:0]  dsc_dpl = '0;
  logic        dsc_code = 1'b0, dsc_conf = 1'b0, dsc_present = 1'b0;
  logic [1:0]  iopl = '0;
  logic        grant, fault;
  logic [1:0]  fault_code, cpl;
  logic [15:0] fault_sel, new_cs, flags_wmask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_priv_check u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .sel(sel), .dsc_dpl(dsc_dpl), .dsc_code(dsc_code), .dsc_conf(dsc_conf),
    .dsc_present(dsc_present), .iopl(iopl), .grant(grant), .fault(fault),
    .fault_code(fault_code), .fault_sel(fault_sel), .new_cs(new_cs),
    .flags_wmask(flags_wmask), .cpl(cpl)
  );

  // kind, sel, dpl, code, conf, present, iopl, exp grant, exp fault code, exp ring after edge
  localparam int NV = 31;
  localparam logic [30:0] VEC [NV] = '{
    {3'd0, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'b00, 2'd0}, // R2 null data
    {3'd0, 16'h0013, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd0}, // R2 RPL weakens
    {3'd0, 16'h0013, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 2'b00, 2'd0}, // R2
    {3'd0, 16'h0010, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'b10, 2'd0}, // R9 not present
    {3'd1, 16'h0020, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 2'b00, 2'd0}, // R3
    {3'd1, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd0}, // R9 null stack
    {3'd1, 16'h0020, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd0}, // R3 ring mismatch
    {3'd1, 16'h0020, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd0}, // R9 type
    {3'd1, 16'h0020, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'b01, 2'd0}, // R9 GP before NP
    {3'd3, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'b00, 2'd0}, // R7
    {3'd4, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'b00, 2'd0}, // R8
    {3'd2, 16'h0030, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 2'b00, 2'd0}, // R5
    {3'd2, 16'h0030, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd0}, // R5 dpl != cpl
    {3'd5, 16'h0049, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 2'b00, 2'd1}, // R6 to ring 1
    {3'd2, 16'h0058, 2'd3, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 2'b01, 2'd1}, // R4 outer conforming
    {3'd2, 16'h0058, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd1}, // R5 outer
    {3'd2, 16'h0048, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 2'b00, 2'd1}, // R5 RPL forced
    {3'd2, 16'h004A, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd1}, // R5 RPL > cpl
    {3'd5, 16'h0048, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd1}, // R6 inward refused
    {3'd3, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'b01, 2'd1}, // R7
    {3'd5, 16'h004B, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 2'b00, 2'd3}, // R6 to ring 3
    {3'd0, 16'h0010, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd3}, // R2 cpl dominates
    {3'd0, 16'h0010, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 2'b00, 2'd3}, // R2
    {3'd1, 16'h0020, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 2'b00, 2'd3}, // R3
    {3'd3, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 2'b01, 2'd3}, // R7
    {3'd3, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 2'b00, 2'd3}, // R7
    {3'd2, 16'h0058, 2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 2'b00, 2'd3}, // R4 ring kept
    {3'd2, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd3}, // R9 null transfer
    {3'd2, 16'h0060, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd3}, // R9 data as code
    {3'd2, 16'h0060, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'b10, 2'd3}, // R9 not present
    {3'd6, 16'h0060, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'b01, 2'd3}  // R9 bad kind
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] k, input logic [15:0] s, input logic [1:0] d,
                       input logic c, input logic cf, input logic p, input logic [1:0] io);
    @(negedge clk);
    req_valid = v; req_kind = k; sel = s; dsc_dpl = d;
    dsc_code = c; dsc_conf = cf; dsc_present = p; iopl = io;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    drive(1'b0, 3'd0, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    rst_n = 1'b1;
    chk(cpl == 2'd0, "R1 reset ring", 32'(cpl), 0);
    chk(!grant && !fault, "R1 idle verdict", {30'd0, grant, fault}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      logic [1:0]  ring_before;
      logic [15:0] exp_cs, exp_fs;
      v = VEC[i];
      drive(1'b1, v[30:28], v[27:12], v[11:10], v[9], v[8], v[7], v[6:5]);
      ring_before = cpl;
      exp_fs = (v[3:2] != 2'b00) ? {v[27:14], 2'b00} : 16'h0000;
      exp_cs = !v[4] ? 16'h0000 :
               (v[30:28] == 3'd2) ? {v[27:14], ring_before} :
               (v[30:28] == 3'd5) ? v[27:12] : 16'h0000;
      chk(grant == v[4], $sformatf("R9 vec %0d grant", i), 32'(grant), 32'(v[4]));
      chk(fault == (v[3:2] != 2'b00), $sformatf("R9 vec %0d fault", i), 32'(fault), 32'(v[3:2] != 2'b00));
      chk(fault_code == v[3:2], $sformatf("R9 vec %0d code", i), 32'(fault_code), 32'(v[3:2]));
      chk(fault_sel == exp_fs, $sformatf("R10 vec %0d fault_sel", i), 32'(fault_sel), 32'(exp_fs));
      chk(new_cs == exp_cs, $sformatf("R5/R6 vec %0d new_cs", i), 32'(new_cs), 32'(exp_cs));
      @(posedge clk); #1;
      chk(cpl == v[1:0], $sformatf("R11 vec %0d ring", i), 32'(cpl), 32'(v[1:0]));
    end

    drive(1'b1, 3'd4, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3);
    chk(flags_wmask == 16'hCDFF, "R8 mask at ring 3", 32'(flags_wmask), 32'hCDFF);

    drive(1'b0, 3'd0, 16'h0013, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0);
    chk(!grant && !fault && fault_code == 2'b00, "R1 idle no verdict", {28'd0, grant, fault, fault_code}, 0);
    chk(fault_sel == 16'h0 && new_cs == 16'h0 && flags_wmask == 16'h0, "R1 idle outputs zero",
        32'(fault_sel | new_cs | flags_wmask), 0);

    drive(1'b0, 3'd0, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    chk(cpl == 2'd0, "R1 ring after second reset", 32'(cpl), 0);

    drive(1'b1, 3'd4, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk(flags_wmask == 16'hFFFF, "R8 mask at ring 0", 32'(flags_wmask), 32'hFFFF);

    drive(1'b0, 3'd5, 16'h004B, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0);
    @(posedge clk); #1;
    chk(cpl == 2'd0, "R11 ungated return ignored", 32'(cpl), 0);

    drive(1'b1, 3'd5, 16'h0048, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0);
    @(posedge clk); #1;
    chk(cpl == 2'd0, "R11 refused return ignored", 32'(cpl), 0);

    drive(1'b0, 3'd0, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule